// File: doc/BRIEF.md
# Mesh Processing Element with Neighbour Forwarding

One node of a two-dimensional array of processing elements used for convolution, where neighbouring nodes reuse each other's input data instead of refetching it. Every cycle the node picks one data word from its right neighbour, its lower neighbour or the input buffer. It latches that word in an input register and may also push it into a horizontal FIFO, a vertical FIFO or both. Those FIFOs feed the neighbouring nodes. The array controller decides when each FIFO presents its next entry.

The latched word then goes through a small arithmetic unit together with a broadcast kernel weight and the node's own output register. The operations are multiply-accumulate, max and min pooling, kernel-plus-data addition and data accumulation. A clear control starts a new output from zero or from the most negative value. The result can update the output register. The node port shows either that register or the raw result of the most recent operation. Data is 16-bit signed fixed point with 10 fraction bits, and every arithmetic result saturates.

Top module: `mesh_pe`

## Requirements
- R1: With `src_sel_i` = 0 the node takes `right_i`, with 1 it takes `lower_i`, and with 2 or 3 it takes `buf_i`.
- R2: `hpush_i` and `vpush_i` independently push the selected word into the horizontal and vertical FIFO at the clock edge. A push into one FIFO leaves the other unchanged.
- R3: Each FIFO is first-in first-out. Its registered output changes only on a pop (`hpop_i` / `vpop_i`), and it shows the popped entry after that edge. A pop while the FIFO is empty leaves the output unchanged.
- R4: Empty and full flags follow the FIFO occupancy (`FIFO_DEPTH` entries). They are never both set. A push into a full FIFO is dropped.
- R5: Op 0 (multiply-add) gives sat(((kernel × data) >>> 10) + base).
- R6: Op 1 gives max(data, base). Op 2 gives min(data, base). Both compare as signed values.
- R7: Op 3 gives sat(kernel + data). Op 4 gives sat(data + base). Ops 5 to 7 pass the data through. Saturation limits are 32767 and −32768.
- R8: base is the output register, except when `clr_i` goes with the operation. In that case base is 0 (`clr_mode_i` = 0) or −32768 (`clr_mode_i` = 1). A clear without `valid_i` loads that value into the output register.
- R9: The result is written to the output register only when `wb_i` is set. `pe_o` shows the last result when `out_sel_i` = 1 and the output register when it is 0.
- R10: After reset, the output register, the result, both FIFO outputs and both FIFOs are zero or empty.
- R11: An operation presented in cycle N is visible on `pe_o` after the second rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Perform an operation this cycle |
| src_sel_i | input | 2 | Data source: 0 right, 1 lower, 2/3 buffer |
| right_i | input | 16 | Data from right neighbour |
| lower_i | input | 16 | Data from lower neighbour |
| buf_i | input | 16 | Data from input buffer |
| kernel_i | input | 16 | Broadcast kernel weight |
| op_i | input | 3 | Operation code |
| clr_i | input | 1 | Start a new output |
| clr_mode_i | input | 1 | Clear value: 0 zero, 1 most negative |
| wb_i | input | 1 | Write result to output register |
| out_sel_i | input | 1 | 1 shows result, 0 shows output register |
| hpush_i | input | 1 | Push selected word to horizontal FIFO |
| vpush_i | input | 1 | Push selected word to vertical FIFO |
| hpop_i | input | 1 | Present next horizontal FIFO entry |
| vpop_i | input | 1 | Present next vertical FIFO entry |
| hfifo_o | output | 16 | Horizontal FIFO output |
| vfifo_o | output | 16 | Vertical FIFO output |
| hfull_o | output | 1 | Horizontal FIFO full |
| hempty_o | output | 1 | Horizontal FIFO empty |
| vfull_o | output | 1 | Vertical FIFO full |
| vempty_o | output | 1 | Vertical FIFO empty |
| pe_o | output | 16 | Node output |

## Verification
The checker watches several properties on every cycle. It confirms that no FIFO flags full and empty at once, that a full FIFO stays full under a lone push, and that a FIFO output holds still without a valid pop. It also confirms that a standalone most-negative clear shows up in the output register two edges later, and that reset empties everything. Other behaviour is visible only through the bench's scenarios: the arithmetic of each operation, saturation, source selection, FIFO ordering with dropped pushes, and the difference between the result and the written-back register. The bench's scoreboard predicts each of those results independently.

// File: rtl/mesh_pe_pkg.sv
package mesh_pe_pkg;
  typedef enum logic [1:0] {
    SRC_RIGHT = 2'd0,
    SRC_LOWER = 2'd1,
    SRC_BUF   = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    OP_MAC  = 3'd0,
    OP_MAX  = 3'd1,
    OP_MIN  = 3'd2,
    OP_VADD = 3'd3,
    OP_ACC  = 3'd4
  } op_e;
endpackage

// File: rtl/pe_fifo.sv
module pe_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == FULLC);
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout_o <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        dout_o <= mem[rd_ptr];
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import mesh_pe_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 10
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] base_i,
  output logic [W-1:0] res_o
);
  localparam int XW = 2 * W + 1;

  logic signed [W-1:0]   xs, ks, bs;
  logic signed [2*W-1:0] prod, prod_sh;
  logic [XW-1:0]         sum;
  logic                  use_sum;
  logic [W:0]            hi;

  function automatic logic [XW-1:0] ext(input logic [W-1:0] v);
    return {{(W+1){v[W-1]}}, v};
  endfunction

  assign xs      = x_i;
  assign ks      = k_i;
  assign bs      = base_i;
  assign prod    = xs * ks;
  assign prod_sh = prod >>> FRAC;
  assign hi      = sum[XW-1:W-1];

  always_comb begin
    sum     = '0;
    use_sum = 1'b1;
    res_o   = x_i;
    case (op_e'(op_i))
      OP_MAC:  sum = {prod_sh[2*W-1], prod_sh} + ext(base_i);
      OP_VADD: sum = ext(x_i) + ext(k_i);
      OP_ACC:  sum = ext(x_i) + ext(base_i);
      OP_MAX: begin use_sum = 1'b0; res_o = (xs > bs) ? x_i : base_i; end
      OP_MIN: begin use_sum = 1'b0; res_o = (xs < bs) ? x_i : base_i; end
      default: use_sum = 1'b0;
    endcase
    if (use_sum) begin
      if ((&hi) || !(|hi)) res_o = sum[W-1:0];
      else if (sum[XW-1])  res_o = {1'b1, {(W-1){1'b0}}};
      else                 res_o = {1'b0, {(W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe
  import mesh_pe_pkg::*;
#(
  parameter int W          = 16,
  parameter int FRAC       = 10,
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [1:0]   src_sel_i,
  input  logic [W-1:0] right_i,
  input  logic [W-1:0] lower_i,
  input  logic [W-1:0] buf_i,
  input  logic [W-1:0] kernel_i,
  input  logic [2:0]   op_i,
  input  logic         clr_i,
  input  logic         clr_mode_i,
  input  logic         wb_i,
  input  logic         out_sel_i,
  input  logic         hpush_i,
  input  logic         vpush_i,
  input  logic         hpop_i,
  input  logic         vpop_i,
  output logic [W-1:0] hfifo_o,
  output logic [W-1:0] vfifo_o,
  output logic         hfull_o,
  output logic         hempty_o,
  output logic         vfull_o,
  output logic         vempty_o,
  output logic [W-1:0] pe_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sel_data;
  logic [W-1:0] in_q, kern_q, out_q, res_q, base, clr_val, alu_res;
  logic [2:0]   op_q;
  logic         v_q, clr_q, clr_mode_q, wb_q;

  always_comb begin
    case (src_e'(src_sel_i))
      SRC_RIGHT: sel_data = right_i;
      SRC_LOWER: sel_data = lower_i;
      default:   sel_data = buf_i;
    endcase
  end

  pe_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_hfifo (
    .clk(clk), .rst(rst), .push_i(hpush_i), .din_i(sel_data), .pop_i(hpop_i),
    .dout_o(hfifo_o), .full_o(hfull_o), .empty_o(hempty_o)
  );

  pe_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_vfifo (
    .clk(clk), .rst(rst), .push_i(vpush_i), .din_i(sel_data), .pop_i(vpop_i),
    .dout_o(vfifo_o), .full_o(vfull_o), .empty_o(vempty_o)
  );

  // Stage 1: input register and captured controls
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0; kern_q <= '0; op_q <= '0;
      v_q <= 1'b0; clr_q <= 1'b0; clr_mode_q <= 1'b0; wb_q <= 1'b0;
    end else begin
      in_q       <= sel_data;
      kern_q     <= kernel_i;
      op_q       <= op_i;
      v_q        <= valid_i;
      clr_q      <= clr_i;
      clr_mode_q <= clr_mode_i;
      wb_q       <= wb_i;
    end
  end

  assign clr_val = clr_mode_q ? MOST_NEG : '0;
  assign base    = clr_q ? clr_val : out_q;

  pe_alu #(.W(W), .FRAC(FRAC)) u_alu (
    .op_i(op_q), .x_i(in_q), .k_i(kern_q), .base_i(base), .res_o(alu_res)
  );

  // Stage 2: result and output register
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      out_q <= '0;
    end else begin
      if (v_q) res_q <= alu_res;
      if (v_q && wb_q)  out_q <= alu_res;
      else if (clr_q)   out_q <= clr_val;
    end
  end

  assign pe_o = out_sel_i ? res_q : out_q;
endmodule

// File: rtl/mesh_pe_chk.sv
module mesh_pe_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic         clr_i,
  input logic         clr_mode_i,
  input logic         out_sel_i,
  input logic         hpush_i,
  input logic         vpush_i,
  input logic         hpop_i,
  input logic         vpop_i,
  input logic [W-1:0] hfifo_o,
  input logic [W-1:0] vfifo_o,
  input logic         hfull_o,
  input logic         hempty_o,
  input logic         vfull_o,
  input logic         vempty_o,
  input logic [W-1:0] pe_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(hfull_o && hempty_o) && !(vfull_o && vempty_o));

  p_hfull_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (hfull_o && hpush_i && !hpop_i) |=> hfull_o);

  p_vfull_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (vfull_o && vpush_i && !vpop_i) |=> vfull_o);

  p_hhold_r3: assert property (@(posedge clk) disable iff (rst)
    (!hpop_i || hempty_o) |=> $stable(hfifo_o));

  p_vhold_r3: assert property (@(posedge clk) disable iff (rst)
    (!vpop_i || vempty_o) |=> $stable(vfifo_o));

  p_clear_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && clr_mode_i && !valid_i) |=> ##1 (out_sel_i || pe_o == MOST_NEG));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (hempty_o && vempty_o && hfifo_o == '0 && vfifo_o == '0));
endmodule

bind mesh_pe mesh_pe_chk #(.W(W)) u_chk (.*);

// File: tb/mesh_pe_tb.sv
module mesh_pe_tb;
  localparam int W = 16;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst;
  logic valid_i, clr_i, clr_mode_i, wb_i, out_sel_i;
  logic hpush_i, vpush_i, hpop_i, vpop_i;
  logic [1:0] src_sel_i;
  logic [2:0] op_i;
  logic [W-1:0] right_i, lower_i, buf_i, kernel_i;
  logic [W-1:0] hfifo_o, vfifo_o, pe_o;
  logic hfull_o, hempty_o, vfull_o, vempty_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic signed [W-1:0] exp_q[$];
  string tag_q[$];
  logic signed [W-1:0] model_acc;
  logic sv1 = 1'b0, sv2 = 1'b0;

  always #5 clk = ~clk;

  mesh_pe #(.W(W), .FRAC(10), .FIFO_DEPTH(D)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Driver: present one operation and queue its predicted result
  task automatic op(input logic [1:0] src, input int rv, input int lv, input int bv,
                    input int k, input logic [2:0] opc, input bit clr, input bit mode,
                    input bit wb, input string tag);
    longint x, base, r;
    @(negedge clk);
    valid_i = 1; src_sel_i = src; right_i = W'(rv); lower_i = W'(lv); buf_i = W'(bv);
    kernel_i = W'(k); op_i = opc; clr_i = clr; clr_mode_i = mode; wb_i = wb;
    x = (src == 2'd0) ? longint'(rv) : (src == 2'd1) ? longint'(lv) : longint'(bv);
    base = clr ? (mode ? -32768 : 0) : longint'(model_acc);
    case (opc)
      3'd0: r = sat(((longint'(k) * x) >>> 10) + base);
      3'd1: r = (x > base) ? x : base;
      3'd2: r = (x < base) ? x : base;
      3'd3: r = sat(longint'(k) + x);
      3'd4: r = sat(x + base);
      default: r = x;
    endcase
    if (wb) model_acc = W'(r);
    exp_q.push_back(W'(r));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0; clr_i = 0; wb_i = 0;
      hpush_i = 0; vpush_i = 0; hpop_i = 0; vpop_i = 0;
    end
  endtask

  // Monitor: R11 latency of two edges
  always @(posedge clk) begin
    sv1 <= valid_i && !rst;
    sv2 <= sv1;
  end

  always @(negedge clk) begin
    if (sv2 && exp_q.size() > 0) begin
      automatic logic signed [W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk($signed(pe_o) == e, {t, " R11"}, $signed(pe_o), e);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; valid_i = 0; clr_i = 0; clr_mode_i = 0; wb_i = 0; out_sel_i = 1;
    hpush_i = 0; vpush_i = 0; hpop_i = 0; vpop_i = 0; src_sel_i = 0; op_i = 0;
    right_i = 0; lower_i = 0; buf_i = 0; kernel_i = 0; model_acc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(hempty_o && vempty_o && !hfull_o && !vfull_o, "R10 flags", hempty_o, 1);
    chk(hfifo_o == 0 && vfifo_o == 0, "R10 fifo out", hfifo_o, 0);
    chk(pe_o == 0, "R10 pe", pe_o, 0);

    // R2: horizontal pushes from right, vertical push from lower
    src_sel_i = 0; right_i = 16'h0011; hpush_i = 1;
    @(negedge clk); right_i = 16'h0022;
    @(negedge clk); hpush_i = 0; src_sel_i = 1; lower_i = 16'h0033; vpush_i = 1;
    @(negedge clk); vpush_i = 0;
    chk(!hempty_o && !vempty_o, "R2 both nonempty", hempty_o, 0);
    // R3 FIFO order and pop-only updates
    chk(hfifo_o == 0, "R3 no pop yet", hfifo_o, 0);
    hpop_i = 1;
    @(negedge clk); chk(hfifo_o == 16'h0011, "R3 first", hfifo_o, 16'h0011);
    @(negedge clk); chk(hfifo_o == 16'h0022, "R3 second", hfifo_o, 16'h0022);
    chk(hempty_o, "R4 empty after drain", hempty_o, 1);
    @(negedge clk); chk(hfifo_o == 16'h0022, "R3 pop empty holds", hfifo_o, 16'h0022);
    hpop_i = 0;
    chk(vfifo_o == 0, "R2 vertical untouched by H pops", vfifo_o, 0);
    vpop_i = 1;
    @(negedge clk); vpop_i = 0;
    chk(vfifo_o == 16'h0033, "R2 vertical entry", vfifo_o, 16'h0033);
    chk(vempty_o, "R4 v empty", vempty_o, 1);

    // R4 fill horizontal from buffer, drop the extra push
    src_sel_i = 2; hpush_i = 1;
    for (int i = 0; i < D; i++) begin
      buf_i = W'(16'h0100 + i);
      @(negedge clk);
    end
    chk(hfull_o && !hempty_o, "R4 full", hfull_o, 1);
    buf_i = 16'h0999;
    @(negedge clk); hpush_i = 0;
    chk(hfull_o, "R4 full after dropped push", hfull_o, 1);
    hpop_i = 1;
    for (int i = 0; i < D; i++) begin
      @(negedge clk);
      chk(hfifo_o == W'(16'h0100 + i), "R4 order kept, extra dropped", hfifo_o, 16'h0100 + i);
    end
    hpop_i = 0;
    chk(hempty_o, "R4 empty at end", hempty_o, 1);

    // Scoreboard phase, showing the result (out_sel_i = 1)
    out_sel_i = 1;
    op(2, 0, 0, 2048, 1024, 3'd0, 1, 0, 1, "R5 R8 mac from zero");
    op(2, 0, 0, -3072, 512, 3'd0, 0, 0, 1, "R5 mac negative");
    op(2, 0, 0, 32767, 32767, 3'd0, 0, 0, 1, "R5 mac saturate");
    op(2, 0, 0, -32768, 0, 3'd4, 1, 0, 1, "R7 R8 acc first");
    op(2, 0, 0, -32768, 0, 3'd4, 0, 0, 1, "R7 acc saturate low");
    op(2, 0, 0, -5, 0, 3'd1, 1, 1, 1, "R6 R8 max from most negative");
    op(2, 0, 0, 7, 0, 3'd1, 0, 0, 1, "R6 max larger");
    op(2, 0, 0, 3, 0, 3'd1, 0, 0, 1, "R6 max smaller");
    op(2, 0, 0, -100, 0, 3'd2, 0, 0, 1, "R6 min");
    op(2, 0, 0, 10000, 30000, 3'd3, 0, 0, 0, "R7 R9 vadd saturate no wb");
    op(0, 111, 222, 333, 0, 3'd3, 0, 0, 0, "R1 right");
    op(1, 111, 222, 333, 0, 3'd3, 0, 0, 0, "R1 lower");
    op(2, 111, 222, 333, 0, 3'd3, 0, 0, 0, "R1 buffer");
    op(3, 111, 222, 333, 0, 3'd3, 0, 0, 0, "R1 code 3 buffer");
    op(2, 0, 0, 1234, 0, 3'd6, 0, 0, 0, "R7 pass");
    idle(3);
    // R9 output register kept the last written value
    out_sel_i = 0;
    #1;
    chk($signed(pe_o) == model_acc, "R9 register view", $signed(pe_o), model_acc);

    // R8 standalone clears
    @(negedge clk); clr_i = 1; clr_mode_i = 1;
    @(negedge clk); clr_i = 0;
    @(negedge clk);
    chk(pe_o == 16'h8000, "R8 clear most negative", $signed(pe_o), -32768);
    clr_i = 1; clr_mode_i = 0;
    @(negedge clk); clr_i = 0;
    @(negedge clk);
    chk(pe_o == 0, "R8 clear zero", pe_o, 0);
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule